// File: doc/BRIEF.md
# Start-Stop Interval Digitizer Back End

This block is the digital back end of a single-shot time-to-digital converter. It measures the interval between one start event and one stop event. It runs on a reference clock whose period is 4 ns. An external delay line samples its 32 taps when each event occurs and passes the two thermometer snapshots in. The block also receives start and stop strobes that are already synchronized to the clock.

Each snapshot is reduced to a 5-bit interpolation code in steps of 1/32 of a clock period (125 ps). A 15-bit counter counts the whole clock periods between the two strobes. The block then forms one 20-bit interval in 1/32-period units: the coarse count shifted left by five, plus the start code, minus the stop code.

The block measures one interval and then holds it. Further strobes are ignored until a synchronous reset re-arms it. The result is a plain held output with no back-pressure: once `done_o` rises, the value stays put until reset, so a consumer may read it at any later cycle. Data moves only in one direction and is never lost, so no ready signal is needed.

Top module: `tdc_backend`

## Requirements
- R1: A snapshot is encoded to the lowest index i for which tap i and tap i+1 are both 0, with the tap above bit 31 taken as 0. If no such index exists the code is 31. A clean thermometer whose n lowest bits are 1 therefore encodes to min(n,31). A stray 1 above the edge has no effect. Each snapshot is sampled only on the clock edge that samples its own strobe.
- R2: A single 0 inside the run of 1s (a bubble at a position below n-1) does not change the code.
- R3: The coarse count equals k, the number of clock edges from the edge that samples `start_i` high up to and including the edge that samples `stop_i` high (k ≥ 1).
- R4: `result_o` equals (32·coarse + start_code − stop_code) modulo 2^20.
- R5: `done_o` stays low on the edge that samples the stop strobe. It rises on the next edge, and at that moment `result_o` is valid.
- R6: Once `done_o` is high, it stays high and `result_o` stays unchanged until reset. Later start or stop strobes have no effect.
- R7: A stop strobe seen before any start strobe is ignored. If start and stop arrive in the same cycle while idle, only the start is taken.
- R8: The coarse counter saturates at 32767. `ovf_o` is set when the counter is asked to advance while already at 32767, so k = 32768 sets it and k = 32767 does not. The flag holds until reset, and the result then uses the count 32767.
- R9: A synchronous reset (`rst` high on a clock edge) clears `done_o`, `ovf_o` and `result_o` to 0 and re-arms the start detector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Synchronized start strobe |
| stop_i | input | 1 | Synchronized stop strobe |
| start_taps_i | input | 32 | Delay-line snapshot taken at the start event |
| stop_taps_i | input | 32 | Delay-line snapshot taken at the stop event |
| result_o | output | 20 | Measured interval in 1/32-period units |
| done_o | output | 1 | Result valid, held until reset |
| ovf_o | output | 1 | Coarse counter overflowed |

## Verification
The assertions check the properties that hold on every cycle:
- once the result is complete, `done_o` and the value stay frozen;
- the overflow flag is sticky, and a saturated counter never moves;
- `done_o` can only rise two edges after a stop strobe was sampled;
- reset clears all outputs.

Only the bench scenarios can show the arithmetic itself. These include the encoding of clean, bubbled and stray-bit snapshots, the exact edge count between strobes, and the negative-fine-difference case. They also include the rejection of early or simultaneous stops and the exact boundary between a count of 32767 and an overflow.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_STOP,
    ST_DONE
  } tdc_state_e;
endpackage

// File: rtl/tdc_therm_enc.sv
module tdc_therm_enc #(
  parameter int TAPS   = 32,
  parameter int CODE_W = $clog2(TAPS)
) (
  input  logic [TAPS-1:0]   taps,
  output logic [CODE_W-1:0] code
);
  // tap above the top of the line reads as not yet reached
  logic [TAPS:0]   ext;
  logic [TAPS-1:0] pair_zero;

  assign ext = {1'b0, taps};

  genvar g;
  generate
    for (g = 0; g < TAPS; g++) begin : g_pz
      assign pair_zero[g] = ~ext[g] & ~ext[g+1];
    end
  endgenerate

  // lowest double-zero marks the edge; a lone 0 bubble is skipped
  always_comb begin
    code = CODE_W'(TAPS - 1);
    for (int i = TAPS - 1; i >= 0; i--) begin
      if (pair_zero[i]) code = CODE_W'(i);
    end
  end
endmodule

// File: rtl/tdc_coarse_cnt.sv
module tdc_coarse_cnt #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt,
  output logic         ovf
);
  localparam logic [W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else if (clr) begin
      cnt <= '0;
    end else if (en) begin
      if (cnt == CNT_MAX) ovf <= 1'b1;
      else                cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tdc_ctrl.sv
module tdc_ctrl
  import tdc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic stop_i,
  output logic cap_start,
  output logic cap_stop,
  output logic cnt_en,
  output logic calc
);
  tdc_state_e state_q, state_d;

  assign cap_start = (state_q == ST_IDLE) && start_i;
  assign cap_stop  = (state_q == ST_RUN) && stop_i;
  assign cnt_en    = (state_q == ST_RUN);
  assign calc      = (state_q == ST_STOP);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start_i) state_d = ST_RUN;
      ST_RUN:  if (stop_i)  state_d = ST_STOP;
      ST_STOP: state_d = ST_DONE;
      default: state_d = ST_DONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/tdc_backend.sv
module tdc_backend #(
  parameter int TAPS     = 32,
  parameter int COARSE_W = 15
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              start_i,
  input  logic                              stop_i,
  input  logic [TAPS-1:0]                   start_taps_i,
  input  logic [TAPS-1:0]                   stop_taps_i,
  output logic [COARSE_W+$clog2(TAPS)-1:0]  result_o,
  output logic                              done_o,
  output logic                              ovf_o
);
  localparam int FINE_W = $clog2(TAPS);
  localparam int RES_W  = COARSE_W + FINE_W;

  logic              cap_start, cap_stop, cnt_en, calc;
  logic [FINE_W-1:0] enc_start, enc_stop;
  logic [FINE_W-1:0] fine_start_q, fine_stop_q;
  logic [COARSE_W-1:0] coarse_cnt;

  tdc_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .stop_i    (stop_i),
    .cap_start (cap_start),
    .cap_stop  (cap_stop),
    .cnt_en    (cnt_en),
    .calc      (calc)
  );

  tdc_therm_enc #(.TAPS(TAPS), .CODE_W(FINE_W)) u_enc_start (
    .taps (start_taps_i),
    .code (enc_start)
  );

  tdc_therm_enc #(.TAPS(TAPS), .CODE_W(FINE_W)) u_enc_stop (
    .taps (stop_taps_i),
    .code (enc_stop)
  );

  tdc_coarse_cnt #(.W(COARSE_W)) u_cnt (
    .clk (clk),
    .rst (rst),
    .clr (cap_start),
    .en  (cnt_en),
    .cnt (coarse_cnt),
    .ovf (ovf_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fine_start_q <= '0;
      fine_stop_q  <= '0;
      result_o     <= '0;
      done_o       <= 1'b0;
    end else begin
      if (cap_start) fine_start_q <= enc_start;
      if (cap_stop)  fine_stop_q  <= enc_stop;
      if (calc) begin
        result_o <= {coarse_cnt, {FINE_W{1'b0}}} + RES_W'(fine_start_q)
                    - RES_W'(fine_stop_q);
        done_o   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tdc_backend_chk.sv
module tdc_backend_chk #(
  parameter int COARSE_W = 15,
  parameter int RES_W    = 20
) (
  input logic                clk,
  input logic                rst,
  input logic                stop_i,
  input logic                done_o,
  input logic                ovf_o,
  input logic [RES_W-1:0]    result_o,
  input logic [COARSE_W-1:0] cnt
);
  localparam logic [COARSE_W-1:0] CNT_MAX = '1;

  // R6
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> done_o);

  // R6
  res_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && $past(done_o)) |-> $stable(result_o));

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_o |=> ovf_o);

  // R8
  cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == CNT_MAX) |=> (cnt == CNT_MAX));

  // R5
  done_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $past(stop_i, 2));

  // R9
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (!done_o && !ovf_o && result_o == '0));
endmodule

bind tdc_backend tdc_backend_chk #(.COARSE_W(COARSE_W), .RES_W(RES_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .stop_i   (stop_i),
  .done_o   (done_o),
  .ovf_o    (ovf_o),
  .result_o (result_o),
  .cnt      (coarse_cnt)
);

// File: tb/sim_tdc_backend.sv
module sim_tdc_backend;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        stop_i = 1'b0;
  logic [31:0] start_taps_i = '0;
  logic [31:0] stop_taps_i = '0;
  logic [19:0] result_o;
  logic        done_o;
  logic        ovf_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  tdc_backend u0 (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .stop_i       (stop_i),
    .start_taps_i (start_taps_i),
    .stop_taps_i  (stop_taps_i),
    .result_o     (result_o),
    .done_o       (done_o),
    .ovf_o        (ovf_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] therm(input int n);
    logic [63:0] v;
    v = (64'h1 << n) - 64'h1;
    return v[31:0];
  endfunction

  function automatic int fcode(input int n);
    return (n > 31) ? 31 : n;
  endfunction

  function automatic logic [31:0] expect_res(input int k, input int fa, input int fb);
    int kk;
    kk = (k > 32767) ? 32767 : k;
    return 32'((kk * 32 + fa - fb) & 32'hFFFFF);
  endfunction

  task automatic do_reset();
    rst = 1'b1; start_i = 1'b0; stop_i = 1'b0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  // start sampled at edge E0, stop sampled at edge Ek
  task automatic measure(input int k, input logic [31:0] a, input logic [31:0] b,
                         input bit dual, input logic [31:0] exp, input bit exp_ovf,
                         input string req);
    start_taps_i = a;
    start_i = 1'b1;
    if (dual) begin stop_i = 1'b1; stop_taps_i = ~b; end
    @(negedge clk);
    start_i = 1'b0; stop_i = 1'b0;
    start_taps_i = $urandom;
    stop_taps_i  = $urandom;
    repeat (k - 1) @(negedge clk);
    chk({req, " R7 done low before stop"}, 32'(done_o), 32'd0);
    stop_taps_i = b;
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    stop_taps_i = $urandom;
    chk("R5 done low on stop edge", 32'(done_o), 32'd0);
    @(negedge clk);
    chk("R5 done high after stop", 32'(done_o), 32'd1);
    chk({req, " R4 result"}, 32'(result_o), exp);
    chk("R8 overflow flag", 32'(ovf_o), 32'(exp_ovf));
  endtask

  initial begin
    void'($urandom(32'd4242));
    do_reset();
    // R9 reset state
    chk("R9 done after reset", 32'(done_o), 32'd0);
    chk("R9 ovf after reset", 32'(ovf_o), 32'd0);
    chk("R9 result after reset", 32'(result_o), 32'd0);

    // R1 R3 R4 minimum interval, negative fine difference
    measure(1, 32'h0, therm(32), 1'b0, expect_res(1, 0, 31), 1'b0, "R3 k=1");
    // R1 clean codes
    do_reset();
    measure(7, therm(13), therm(4), 1'b0, expect_res(7, 13, 4), 1'b0, "R1 clean");
    // R1 stray 1 above the edge
    do_reset();
    measure(3, therm(5) | 32'h0010_0000, therm(0) | 32'h8000_0000, 1'b0,
            expect_res(3, 5, 0), 1'b0, "R1 stray");
    // R2 bubble inside the ones
    do_reset();
    measure(9, therm(20) & ~32'h80, therm(30) & ~32'h1, 1'b0,
            expect_res(9, 20, 30), 1'b0, "R2 bubble");

    // R6 later strobes ignored after done
    begin
      logic [19:0] held;
      held = result_o;
      start_taps_i = therm(2); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      repeat (3) @(negedge clk);
      stop_taps_i = therm(28); stop_i = 1'b1;
      @(negedge clk); stop_i = 1'b0;
      repeat (3) @(negedge clk);
      chk("R6 result held", 32'(result_o), 32'(held));
      chk("R6 done held", 32'(done_o), 32'd1);
    end

    // R9 reset clears a finished measurement
    do_reset();
    chk("R9 result cleared", 32'(result_o), 32'd0);
    chk("R9 done cleared", 32'(done_o), 32'd0);

    // R7 stop before start ignored
    stop_taps_i = therm(3); stop_i = 1'b1;
    @(negedge clk); stop_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 early stop ignored", 32'(done_o), 32'd0);
    measure(6, therm(11), therm(17), 1'b0, expect_res(6, 11, 17), 1'b0, "R7 after early stop");
    // R7 simultaneous start and stop
    do_reset();
    measure(5, therm(25), therm(8), 1'b1, expect_res(5, 25, 8), 1'b0, "R7 simultaneous");

    // R1 R2 R3 R4 random intervals
    for (int it = 0; it < 25; it++) begin
      int k, na, nb;
      logic [31:0] a, b;
      k  = 1 + int'($urandom % 300);
      na = int'($urandom % 33);
      nb = int'($urandom % 33);
      a = therm(na);
      b = therm(nb);
      if (na >= 2 && $urandom % 2 == 1) a[$urandom % (na - 1)] = 1'b0;
      if (nb >= 2 && $urandom % 2 == 1) b[$urandom % (nb - 1)] = 1'b0;
      do_reset();
      measure(k, a, b, 1'b0, expect_res(k, fcode(na), fcode(nb)), 1'b0, "R3 random");
    end

    // R8 boundary: largest count without overflow
    do_reset();
    measure(32767, therm(1), therm(2), 1'b0, expect_res(32767, 1, 2), 1'b0, "R8 k=32767");
    // R8 one more edge overflows and saturates
    do_reset();
    measure(32768, therm(9), therm(3), 1'b0, expect_res(32768, 9, 3), 1'b1, "R8 k=32768");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule